// File: doc/BRIEF.md
# Page-Mode Read Burst Controller

This block decides, for every read or write that the memory interface issues to the asynchronous external bus, whether a read can be served as a short page-mode beat inside an already open burst or needs a full-timing access. Fast page mode exists only for chip-select area 0. A burst opens on any area-0 read while bursts are enabled. It stays open while further reads arrive at exactly the next sequential address and stay inside one aligned address window. The window size comes from a 3-bit boundary code. While a burst is open, chip-select and the read strobe stay low between beats and only the address lines move.

Requests arrive on a valid/ready stream. A request is taken in the cycle where `req_valid` and `req_ready` are both high. While `req_ready` is low the requester holds `req_valid` and all request fields stable. Each accepted request produces one beat. The beat shows the chosen wait-state count and the beat kind, and marks the data sample cycle for the pin-level timing sequencer. The `hold_cs` output tells that sequencer to keep chip-select and the read strobe asserted after the beat. Configuration inputs are plain levels and are only changed while no beat is active.

Top module: `apm_burst_ctrl`

## Requirements
- R1: `cfg_bnd` codes 1 to 6 enable bursts with an aligned window of 4, 8, 16, 32, 64 or 128 bytes (window bytes = 2^(code+1)). Codes 0 and 7 disable bursts: no beat is ever a page beat and `hold_cs` stays 0.
- R2: A read that does not continue an open burst is a full beat: `beat_page`=0 and `beat_ws`=`cfg_ws_full`.
- R3: A read that continues an open burst is a page beat: `beat_page`=1 and `beat_ws`=`cfg_ws_page` zero-extended.
- R4: A beat keeps `beat_active` high for exactly `beat_ws`+1 cycles, starting the cycle after acceptance. `beat_sample` is high in its last cycle only, and `beat_ws` stays stable throughout.
- R5: After an accepted read to area 0 with bursts enabled, `hold_cs`=1. After an accepted write or an access outside area 0, `hold_cs`=0 and the next read is a full beat. An access outside area 0 is never a page beat.
- R6: A `cs0_drop` pulse closes the open burst (`hold_cs`=0 the next cycle). If it coincides with an accepted read, that read is a full beat and opens a new burst.
- R7: A read at any address other than the next sequential one, or one whose address sits on the start of an aligned window, is a full beat and restarts the burst.
- R8: The next sequential address is the previous address plus 1 when `cfg_dw16`=0 and plus 2 when `cfg_dw16`=1.
- R9: `req_ready` is high whenever no beat is active and in the last cycle of a beat, and low otherwise. An accepted request starts its beat in the next cycle, so beats can run back to back.
- R10: After reset no beat is active, `hold_cs`=0, `beat_page`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bnd | input | 3 | Burst window code |
| cfg_ws_full | input | 6 | Wait states of a full-timing beat |
| cfg_ws_page | input | 4 | Wait states of a page beat |
| cfg_dw16 | input | 1 | 1: 16-bit device (step 2), 0: 8-bit device (step 1) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | AW | Byte address of the request |
| req_write | input | 1 | 1: write, 0: read |
| req_area0 | input | 1 | Request targets chip-select area 0 |
| cs0_drop | input | 1 | Area-0 chip-select goes inactive |
| beat_active | output | 1 | A beat is in progress |
| beat_ws | output | 6 | Wait-state count of the current beat |
| beat_page | output | 1 | Current beat is a page beat |
| beat_sample | output | 1 | Data sample cycle (last cycle of beat) |
| hold_cs | output | 1 | Keep chip-select and read strobe low after the beat |

## Verification
The termination input and the acceptance of a request can fall in the same cycle. A sequential read that would otherwise continue the burst can therefore arrive together with a `cs0_drop` pulse. The bench drives exactly that pairing in every configuration. It expects a full beat with `hold_cs` set again, followed by a page beat on the next sequential read. The other collision is a beat's last cycle overlapping the next acceptance. It is judged by requiring `req_ready` in the sample cycle and checking the length of every beat.

// File: rtl/apm_pkg.sv
package apm_pkg;
  localparam int BND_W = 3;
  localparam int WS_W  = 6;
  localparam int PWS_W = 4;

  typedef struct packed {
    logic            page;
    logic [WS_W-1:0] ws;
  } beat_sel_t;
endpackage

// File: rtl/apm_bnd_decode.sv
module apm_bnd_decode #(
  parameter int AW = 16
) (
  input  logic [apm_pkg::BND_W-1:0] code,
  output logic                      en,
  output logic [AW-1:0]             mask
);
  always_comb begin
    en = (code != '0) && (code != '1);
    for (int i = 0; i < AW; i++) begin
      mask[i] = en && (i < int'(code) + 1);
    end
  end
endmodule

// File: rtl/apm_burst_track.sv
module apm_burst_track #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          rd_cand,
  input  logic [AW-1:0] addr,
  input  logic          dw16,
  input  logic [AW-1:0] mask,
  input  logic          drop,
  output logic          cont,
  output logic          open
);
  logic [AW-1:0] nxt;
  logic [AW-1:0] step;

  assign step = {{(AW-2){1'b0}}, dw16, ~dw16};
  // continuation: same window, exact next address, no termination now
  assign cont = open && rd_cand && !drop && (addr == nxt) && |(addr & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open <= 1'b0;
      nxt  <= '0;
    end else if (acc) begin
      open <= rd_cand;
      nxt  <= addr + step;
    end else if (drop) begin
      open <= 1'b0;
    end
  end
endmodule

// File: rtl/apm_beat_timer.sv
module apm_beat_timer #(
  parameter int WW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic [WW-1:0] ws_load,
  output logic          active,
  output logic          last,
  output logic          ready
);
  logic [WW-1:0] cnt;

  assign last  = active && (cnt == '0);
  assign ready = !active || last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (acc) begin
      active <= 1'b1;
      cnt    <= ws_load;
    end else if (last) begin
      active <= 1'b0;
    end else if (active) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/apm_burst_ctrl.sv
module apm_burst_ctrl #(
  parameter int AW = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [apm_pkg::BND_W-1:0] cfg_bnd,
  input  logic [apm_pkg::WS_W-1:0]  cfg_ws_full,
  input  logic [apm_pkg::PWS_W-1:0] cfg_ws_page,
  input  logic                      cfg_dw16,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [AW-1:0]             req_addr,
  input  logic                      req_write,
  input  logic                      req_area0,
  input  logic                      cs0_drop,
  output logic                      beat_active,
  output logic [apm_pkg::WS_W-1:0]  beat_ws,
  output logic                      beat_page,
  output logic                      beat_sample,
  output logic                      hold_cs
);
  import apm_pkg::*;

  logic          acc;
  logic          en;
  logic [AW-1:0] mask;
  logic          rd_cand;
  logic          cont;
  logic          open;
  beat_sel_t     sel;
  beat_sel_t     cur;

  assign acc     = req_valid && req_ready;
  assign rd_cand = en && req_area0 && !req_write;

  apm_bnd_decode #(.AW(AW)) u_dec (
    .code (cfg_bnd),
    .en   (en),
    .mask (mask)
  );

  apm_burst_track #(.AW(AW)) u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc     (acc),
    .rd_cand (rd_cand),
    .addr    (req_addr),
    .dw16    (cfg_dw16),
    .mask    (mask),
    .drop    (cs0_drop),
    .cont    (cont),
    .open    (open)
  );

  always_comb begin
    sel.page = cont;
    sel.ws   = cont ? {{(WS_W-PWS_W){1'b0}}, cfg_ws_page} : cfg_ws_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else if (acc) cur <= sel;
  end

  apm_beat_timer #(.WW(WS_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc     (acc),
    .ws_load (sel.ws),
    .active  (beat_active),
    .last    (beat_sample),
    .ready   (req_ready)
  );

  assign beat_ws   = cur.ws;
  assign beat_page = cur.page;
  assign hold_cs   = open;
endmodule

// File: rtl/apm_burst_ctrl_chk.sv
module apm_burst_ctrl_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    cfg_bnd,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic          req_area0,
  input logic          cs0_drop,
  input logic          beat_active,
  input logic [5:0]    beat_ws,
  input logic          beat_page,
  input logic          beat_sample,
  input logic          hold_cs
);
  logic       acc;
  logic [6:0] len;

  assign acc = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len <= '0;
    else if (beat_active && !beat_sample) len <= len + 1'b1;
    else len <= '0;
  end

  assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_active |-> req_ready);
  assert_accept_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> beat_active);
  assert_sample_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_sample |-> (len == {1'b0, beat_ws}));
  assert_sample_in_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_sample |-> beat_active);
  assert_beat_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_active && !beat_sample) |=> (beat_active && $stable(beat_ws)));
  assert_write_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write) |=> !hold_cs);
  assert_other_area_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_area0) |=> (!beat_page && !hold_cs));
  assert_drop_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs0_drop && !acc) |=> !hold_cs);
  assert_drop_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cs0_drop) |=> !beat_page);
  assert_fresh_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !hold_cs) |=> !beat_page);
  assert_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (cfg_bnd == 3'd0 || cfg_bnd == 3'd7)) |=> (!beat_page && !hold_cs));
endmodule

bind apm_burst_ctrl apm_burst_ctrl_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_bnd     (cfg_bnd),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_write   (req_write),
  .req_area0   (req_area0),
  .cs0_drop    (cs0_drop),
  .beat_active (beat_active),
  .beat_ws     (beat_ws),
  .beat_page   (beat_page),
  .beat_sample (beat_sample),
  .hold_cs     (hold_cs)
);

// File: tb/apm_burst_ctrl_test.sv
module apm_burst_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_bnd = '0;
  logic [5:0]  cfg_ws_full = '0;
  logic [3:0]  cfg_ws_page = '0;
  logic        cfg_dw16 = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_area0 = 1'b0;
  logic        cs0_drop = 1'b0;
  logic        beat_active;
  logic [5:0]  beat_ws;
  logic        beat_page;
  logic        beat_sample;
  logic        hold_cs;

  int n_tests = 0;
  int n_fail  = 0;

  // bench model state
  bit m_open = 0;
  int m_next = 0;

  always #2 clk = ~clk;

  apm_burst_ctrl uut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit cfg_en();
    return (cfg_bnd != 3'd0) && (cfg_bnd != 3'd7);
  endfunction

  task automatic do_req(input int a, input bit wr, input bit a0, input bit dr);
    bit    en, rdc, cont;
    int    mask, step, ews, len;
    string tag;
    en   = cfg_en();
    mask = en ? ((1 << (int'(cfg_bnd) + 1)) - 1) : 0;
    step = cfg_dw16 ? 2 : 1;
    rdc  = en && a0 && !wr;
    cont = m_open && rdc && !dr && (a == m_next) && ((a & mask) != 0);
    ews  = cont ? int'(cfg_ws_page) : int'(cfg_ws_full);
    if (cont) tag = cfg_dw16 ? "R3/R8" : "R3";
    else if (!en) tag = "R1";
    else if (dr) tag = "R6";
    else if (wr || !a0) tag = "R5";
    else if (!m_open) tag = "R2";
    else tag = "R7";
    @(negedge clk);
    req_valid = 1'b1; req_addr = a[15:0]; req_write = wr; req_area0 = a0; cs0_drop = dr;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; cs0_drop = 1'b0;
    m_open = rdc;
    m_next = (a + step) & 16'hFFFF;
    check(beat_active == 1'b1, "R9 beat starts", int'(beat_active), 1);
    check(beat_page == cont, {tag, " page flag"}, int'(beat_page), int'(cont));
    check(int'(beat_ws) == ews, {tag, " wait states"}, int'(beat_ws), ews);
    check(hold_cs == rdc, {tag, " hold_cs"}, int'(hold_cs), int'(rdc));
    len = 1;
    while (!beat_sample && len < 80) begin
      @(negedge clk);
      len++;
    end
    check(len == ews + 1, "R4 beat length", len, ews + 1);
    check(req_ready == 1'b1, "R9 ready in sample cycle", int'(req_ready), 1);
  endtask

  task automatic drop_only();
    @(negedge clk); cs0_drop = 1'b1;
    @(negedge clk); cs0_drop = 1'b0;
    m_open = 0;
    check(hold_cs == 1'b0, "R6 drop closes burst", int'(hold_cs), 0);
  endtask

  initial begin
    #(4 * 190000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(beat_active == 1'b0, "R10 idle after reset", int'(beat_active), 0);
    check(hold_cs == 1'b0, "R10 hold clear", int'(hold_cs), 0);
    check(beat_page == 1'b0, "R10 page clear", int'(beat_page), 0);
    check(req_ready == 1'b1, "R10 ready", int'(req_ready), 1);
    for (int c = 0; c < 8; c++) begin
      for (int d = 0; d < 2; d++) begin
        cfg_bnd     = 3'(c);
        cfg_dw16    = d[0];
        cfg_ws_full = 6'(2 + c + d);
        cfg_ws_page = 4'((c * 5 + d * 7) % 16);
        for (int k = 0; k < 40; k++) do_req(16'h01F0 + k * (d + 1), 0, 1, 0);
        do_req(16'h0300, 0, 1, 0);            // R7 non-sequential
        do_req(m_next, 0, 1, 0);
        do_req(m_next + 4, 0, 1, 0);          // R7 gap
        do_req(m_next, 1, 1, 0);              // R5 write
        do_req(m_next, 0, 1, 0);
        do_req(m_next, 0, 1, 0);
        drop_only();                          // R6
        do_req(m_next, 0, 1, 0);
        do_req(m_next, 0, 1, 0);
        do_req(m_next, 0, 0, 0);              // R5 other area
        do_req(m_next, 0, 1, 0);
        do_req(m_next, 0, 1, 1);              // R6 drop with accept
        do_req(m_next, 0, 1, 0);
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule